// File: doc/BRIEF.md
# Interrupt Register Bank Allocator

This block picks where the processor's working context goes when an exception is accepted. It holds a fill level for a set of hardware register banks. For each accepted exception it decides on one of four outcomes: write the context into the next free bank, ask for the context to be pushed to the stack, raise a bank overflow exception, or do nothing at all. A bank holds general registers R0 to R14, the global base register, the two multiply-accumulate halves, the procedure return register and the vector number. The block writes all of these as one wide word.

Only ordinary maskable interrupts can use a bank, and only while banking is enabled. Non-maskable interrupts, break-controller interrupts, address errors and instruction-caused exceptions never touch the banks. Once every bank is occupied, a configuration input chooses what happens next. Either the context falls back to the stack without any signal, or a dedicated overflow exception is raised. This block has no path for restoring a bank. The fill level therefore only rises until the next reset.

Top module: `irq_bank_alloc`

## Requirements
- R1: Reset (synchronous, active high) sets `bank_level` to 0 and drives `bank_we`, `stack_save` and `ovf_exc` low in the cycle after reset.
- R2: When `acc_valid` is high with kind 0 (maskable interrupt), `bank_en` is high and `bank_level` is below 15, `bank_we` goes high in the next cycle. In that cycle `bank_sel` equals the old level and `bank_level` has risen by one.
- R3: The wide word on `bank_wdata` holds the vector in bits [8:0], PR in [40:9], MACL in [72:41], MACH in [104:73] and GBR in [136:105]. General register Rn sits at bits [137+32n +: 32] for n = 0..14. All fields are captured from the accept cycle.
- R4: An accept with kind 1 (NMI), kind 2 (break controller), kind 3 (address error) or kind 4 (instruction exception) produces no `bank_we`, no `stack_save` and no `ovf_exc`, and leaves `bank_level` unchanged.
- R5: A maskable interrupt accepted while `bank_en` is low produces none of the three outputs and leaves `bank_level` unchanged.
- R6: With `bank_level` at 15 (full), a bank-eligible accept with `ovf_exc_en` low produces a one-cycle `stack_save` in the next cycle, and the level stays at 15.
- R7: With `bank_level` at 15, a bank-eligible accept with `ovf_exc_en` high produces a one-cycle `ovf_exc` in the next cycle, and the level stays at 15.
- R8: At most one of `bank_we`, `stack_save` and `ovf_exc` is high in any cycle. All three are low in a cycle that follows a cycle without `acc_valid`.
- R9: Kind codes 5 to 7 are treated as non-bankable: no output is produced and the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An exception is accepted this cycle |
| acc_kind | input | 3 | Exception class: 0 maskable, 1 NMI, 2 break, 3 address error, 4 instruction |
| acc_vector | input | 9 | Vector number of the accepted exception |
| bank_en | input | 1 | Register banking enabled |
| ovf_exc_en | input | 1 | Raise overflow exception instead of stack fallback when full |
| ctx_gpr | input | 480 | R0..R14, Rn at bits [32n +: 32] |
| ctx_gbr | input | 32 | Global base register |
| ctx_mach | input | 32 | Multiply-accumulate high |
| ctx_macl | input | 32 | Multiply-accumulate low |
| ctx_pr | input | 32 | Procedure return register |
| bank_we | output | 1 | Write the whole bank word this cycle |
| bank_sel | output | 4 | Bank index being written |
| bank_wdata | output | 617 | Packed bank contents |
| stack_save | output | 1 | Context must be pushed to the stack |
| ovf_exc | output | 1 | Bank overflow exception pulse |
| bank_level | output | 4 | Banks in use; 15 means full |

## Verification
The full condition is the hardest to reach from the ports. Getting there takes fifteen bank-eligible accepts with no reset in between. Any other accepts must be non-bankable, or must arrive while banking is disabled. Uniform random stimulus would rarely manage this. The stimulus therefore weights maskable interrupts heavily and resets only rarely. It also adds directed runs that fill every bank and then try both settings of the overflow-enable input. Those runs mix non-bankable kinds and unused kind codes into a partly full level and into a full one.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    KIND_IRQ   = 3'd0,
    KIND_NMI   = 3'd1,
    KIND_BRK   = 3'd2,
    KIND_ADERR = 3'd3,
    KIND_INSN  = 3'd4
  } irq_kind_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_BANK  = 2'd1,
    ACT_STACK = 2'd2,
    ACT_OVF   = 2'd3
  } bank_act_e;

endpackage

// File: rtl/irq_bank_classify.sv
module irq_bank_classify
  import irq_bank_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] kind,
  input  logic       bank_en,
  input  logic       ovf_exc_en,
  input  logic       full,
  output bank_act_e  act
);

  logic bankable;

  always_comb begin
    case (kind)
      KIND_IRQ:   bankable = 1'b1;
      KIND_NMI,
      KIND_BRK,
      KIND_ADERR,
      KIND_INSN:  bankable = 1'b0;
      default:    bankable = 1'b0;
    endcase
  end

  always_comb begin
    act = ACT_NONE;
    if (valid && bankable && bank_en) begin
      if (!full)          act = ACT_BANK;
      else if (ovf_exc_en) act = ACT_OVF;
      else                act = ACT_STACK;
    end
  end

endmodule

// File: rtl/irq_bank_level.sv
module irq_bank_level #(
  parameter int NUM_BANKS = 15,
  parameter int LVL_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [LVL_W-1:0] level,
  output logic             full
);

  localparam logic [LVL_W-1:0] FULL_CODE = LVL_W'(NUM_BANKS);

  assign full = (level == FULL_CODE);

  always_ff @(posedge clk) begin
    if (rst)              level <= '0;
    else if (inc && !full) level <= level + 1'b1;
  end

endmodule

// File: rtl/irq_bank_pack.sv
module irq_bank_pack #(
  parameter int WORD_W  = 32,
  parameter int VEC_W   = 9,
  parameter int NUM_GPR = 15,
  localparam int GPR_BASE = VEC_W + 4 * WORD_W,
  localparam int DATA_W   = GPR_BASE + NUM_GPR * WORD_W
) (
  input  logic [VEC_W-1:0]          vector,
  input  logic [NUM_GPR*WORD_W-1:0] gpr,
  input  logic [WORD_W-1:0]         gbr,
  input  logic [WORD_W-1:0]         mach,
  input  logic [WORD_W-1:0]         macl,
  input  logic [WORD_W-1:0]         pr,
  output logic [DATA_W-1:0]         word
);

  assign word[VEC_W-1:0]                   = vector;
  assign word[VEC_W + 0*WORD_W +: WORD_W]  = pr;
  assign word[VEC_W + 1*WORD_W +: WORD_W]  = macl;
  assign word[VEC_W + 2*WORD_W +: WORD_W]  = mach;
  assign word[VEC_W + 3*WORD_W +: WORD_W]  = gbr;

  for (genvar n = 0; n < NUM_GPR; n++) begin : g_gpr
    assign word[GPR_BASE + n*WORD_W +: WORD_W] = gpr[n*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/irq_bank_alloc.sv
module irq_bank_alloc
  import irq_bank_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int VEC_W     = 9,
  parameter int NUM_GPR   = 15,
  parameter int NUM_BANKS = 15,
  localparam int LVL_W    = $clog2(NUM_BANKS + 1),
  localparam int DATA_W   = VEC_W + (4 + NUM_GPR) * WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_valid,
  input  logic [2:0]                acc_kind,
  input  logic [VEC_W-1:0]          acc_vector,
  input  logic                      bank_en,
  input  logic                      ovf_exc_en,
  input  logic [NUM_GPR*WORD_W-1:0] ctx_gpr,
  input  logic [WORD_W-1:0]         ctx_gbr,
  input  logic [WORD_W-1:0]         ctx_mach,
  input  logic [WORD_W-1:0]         ctx_macl,
  input  logic [WORD_W-1:0]         ctx_pr,
  output logic                      bank_we,
  output logic [LVL_W-1:0]          bank_sel,
  output logic [DATA_W-1:0]         bank_wdata,
  output logic                      stack_save,
  output logic                      ovf_exc,
  output logic [LVL_W-1:0]          bank_level
);

  bank_act_e         act;
  logic              full;
  logic [DATA_W-1:0] packed_word;

  irq_bank_level #(.NUM_BANKS(NUM_BANKS), .LVL_W(LVL_W)) u_level (
    .clk   (clk),
    .rst   (rst),
    .inc   (act == ACT_BANK),
    .level (bank_level),
    .full  (full)
  );

  irq_bank_classify u_class (
    .valid      (acc_valid),
    .kind       (acc_kind),
    .bank_en    (bank_en),
    .ovf_exc_en (ovf_exc_en),
    .full       (full),
    .act        (act)
  );

  irq_bank_pack #(.WORD_W(WORD_W), .VEC_W(VEC_W), .NUM_GPR(NUM_GPR)) u_pack (
    .vector (acc_vector),
    .gpr    (ctx_gpr),
    .gbr    (ctx_gbr),
    .mach   (ctx_mach),
    .macl   (ctx_macl),
    .pr     (ctx_pr),
    .word   (packed_word)
  );

  // control outputs: reset, one-cycle pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_we    <= 1'b0;
      stack_save <= 1'b0;
      ovf_exc    <= 1'b0;
    end else begin
      bank_we    <= (act == ACT_BANK);
      stack_save <= (act == ACT_STACK);
      ovf_exc    <= (act == ACT_OVF);
    end
  end

  // data path: no reset, loaded only on a bank save
  always_ff @(posedge clk) begin
    if (act == ACT_BANK) begin
      bank_sel   <= bank_level;
      bank_wdata <= packed_word;
    end
  end

endmodule

// File: rtl/irq_bank_alloc_chk.sv
module irq_bank_alloc_chk #(
  parameter int NUM_BANKS = 15,
  parameter int LVL_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic [2:0]       acc_kind,
  input logic             bank_en,
  input logic             ovf_exc_en,
  input logic             bank_we,
  input logic [LVL_W-1:0] bank_sel,
  input logic             stack_save,
  input logic             ovf_exc,
  input logic [LVL_W-1:0] bank_level
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(NUM_BANKS);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (bank_level == '0) && !bank_we && !stack_save && !ovf_exc);

  p_we_advances_r2: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> (bank_level == bank_sel + 1'b1));

  p_nonirq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind != 3'd0) |=> !bank_we && !stack_save && !ovf_exc);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !bank_en) |=> !bank_we && !stack_save && !ovf_exc);

  p_full_stack_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 3'd0 && bank_en && bank_level == FULL && !ovf_exc_en)
      |=> stack_save && (bank_level == FULL));

  p_full_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 3'd0 && bank_en && bank_level == FULL && ovf_exc_en)
      |=> ovf_exc && (bank_level == FULL));

  p_one_action_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bank_we, stack_save, ovf_exc}));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !bank_we && !stack_save && !ovf_exc);

endmodule

bind irq_bank_alloc irq_bank_alloc_chk #(.NUM_BANKS(NUM_BANKS), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .bank_en    (bank_en),
  .ovf_exc_en (ovf_exc_en),
  .bank_we    (bank_we),
  .bank_sel   (bank_sel),
  .stack_save (stack_save),
  .ovf_exc    (ovf_exc),
  .bank_level (bank_level)
);

// File: tb/tb_irq_bank_alloc.sv
module tb_irq_bank_alloc;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int V  = 9;
  localparam int G  = 15;
  localparam int NB = 15;
  localparam int LW = 4;
  localparam int DW = V + (4 + G) * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [2:0]    acc_kind = '0;
  logic [V-1:0]  acc_vector = '0;
  logic          bank_en = 1'b0;
  logic          ovf_exc_en = 1'b0;
  logic [G*W-1:0] ctx_gpr = '0;
  logic [W-1:0]  ctx_gbr = '0, ctx_mach = '0, ctx_macl = '0, ctx_pr = '0;
  logic          bank_we, stack_save, ovf_exc;
  logic [LW-1:0] bank_sel, bank_level;
  logic [DW-1:0] bank_wdata;

  irq_bank_alloc dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_vector(acc_vector), .bank_en(bank_en), .ovf_exc_en(ovf_exc_en),
    .ctx_gpr(ctx_gpr), .ctx_gbr(ctx_gbr), .ctx_mach(ctx_mach),
    .ctx_macl(ctx_macl), .ctx_pr(ctx_pr), .bank_we(bank_we),
    .bank_sel(bank_sel), .bank_wdata(bank_wdata), .stack_save(stack_save),
    .ovf_exc(ovf_exc), .bank_level(bank_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit armed  = 0;

  // expectations for the coming edge
  bit            e_we, e_ss, e_ov;
  logic [LW-1:0] e_sel, e_lvl;
  logic [DW-1:0] e_data;
  string         e_tag;
  int            lvl_m = 0;

  function automatic logic [DW-1:0] exp_word(logic [V-1:0] vec, logic [G*W-1:0] gpr,
      logic [W-1:0] gbr, logic [W-1:0] mach, logic [W-1:0] macl, logic [W-1:0] pr);
    logic [DW-1:0] w;
    w[8:0]     = vec;
    w[40:9]    = pr;
    w[72:41]   = macl;
    w[104:73]  = mach;
    w[136:105] = gbr;
    for (int n = 0; n < G; n++) w[137 + 32*n +: 32] = gpr[32*n +: 32];
    return w;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(e_tag, "bank_we", bank_we, e_we);
    chk(e_tag, "stack_save", stack_save, e_ss);
    chk(e_tag, "ovf_exc", ovf_exc, e_ov);
    chk(e_tag, "bank_level", bank_level, e_lvl);
    chk("R8", "action_count", int'(bank_we) + int'(stack_save) + int'(ovf_exc),
        int'(e_we) + int'(e_ss) + int'(e_ov));
    if (e_we) begin
      chk("R2", "bank_sel", bank_sel, e_sel);
      checks++;
      if (bank_wdata !== e_data) begin
        fails++;
        $display("FAIL R3 bank_wdata actual=%h expected=%h", bank_wdata, e_data);
      end
    end
  endtask

  task automatic tick(bit r, bit v, logic [2:0] k, bit ben, bit oen);
    bit elig;
    @(negedge clk);
    if (armed) check_outputs();
    armed = 1;
    rst = r; acc_valid = v; acc_kind = k; bank_en = ben; ovf_exc_en = oen;
    acc_vector = V'($urandom);
    for (int n = 0; n < G; n++) ctx_gpr[n*W +: W] = $urandom;
    ctx_gbr = $urandom; ctx_mach = $urandom; ctx_macl = $urandom; ctx_pr = $urandom;
    e_we = 0; e_ss = 0; e_ov = 0;
    if (r) begin
      lvl_m = 0; e_tag = "R1";
    end else begin
      elig = v && (k == 3'd0) && ben;
      if (!v)                 e_tag = "R8";
      else if (k > 3'd4)      e_tag = "R9";
      else if (k != 3'd0)     e_tag = "R4";
      else if (!ben)          e_tag = "R5";
      else if (lvl_m < NB)    e_tag = "R2";
      else if (oen)           e_tag = "R7";
      else                    e_tag = "R6";
      if (elig && lvl_m < NB) begin
        e_we = 1; e_sel = LW'(lvl_m);
        e_data = exp_word(acc_vector, ctx_gpr, ctx_gbr, ctx_mach, ctx_macl, ctx_pr);
        lvl_m++;
      end else if (elig) begin
        if (oen) e_ov = 1; else e_ss = 1;
      end
    end
    e_lvl = LW'(lvl_m);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    tick(1, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0);
    // R9: unused kind codes at empty level
    for (int k = 5; k < 8; k++) tick(0, 1, 3'(k), 1, 0);
    // R4 / R5 at empty level
    for (int k = 1; k < 5; k++) tick(0, 1, 3'(k), 1, 1);
    tick(0, 1, 0, 0, 0);
    // R2/R3: fill all banks with non-bankable accepts interleaved
    for (int i = 0; i < NB; i++) begin
      tick(0, 1, 0, 1, 0);
      if (i % 4 == 1) tick(0, 1, 3'(1 + i % 4), 1, 0);
      if (i % 5 == 2) tick(0, 0, 0, 1, 0);
    end
    // R6 then R7 at full, with R4/R9 in between
    tick(0, 1, 0, 1, 0);
    tick(0, 1, 0, 1, 0);
    tick(0, 1, 3'd2, 1, 1);
    tick(0, 1, 0, 1, 1);
    tick(0, 1, 3'd6, 1, 1);
    tick(0, 1, 0, 1, 1);
    tick(0, 1, 0, 0, 1);
    tick(0, 0, 0, 1, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit r   = ($urandom % 120) == 0;
      bit v   = ($urandom % 10) < 8;
      int kp  = $urandom % 100;
      logic [2:0] k = (kp < 70) ? 3'd0 : 3'($urandom % 8);
      bit ben = ($urandom % 10) < 9;
      bit oen = $urandom % 2;
      tick(r, v, k, ben, oen);
    end
    tick(0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule